// File: doc/BRIEF.md
# Two-Digit Decimal Countdown Timer

This block is a clocked two-digit decimal countdown timer. Two identical digit cells each hold one BCD value from 0 to 9. Each cell can step up or down and wraps in decimal. Each cell raises a flag when its value is zero. A sequencing controller reads three single-cycle button pulses: start/stop, set-tens and set-ones. It steps through five phases: idle, set-tens, set-ones, run and stop. It drives the digit cells through a small bundle of up and down strobes.

The user first picks a digit with its set button. Each further press of that button adds one to the digit, and the digit wraps from 9 back to 0. A start/stop press begins the countdown. In run, each single-cycle tick takes one from the ones digit. When the ones digit is already zero, it returns to 9 and the tens digit takes the borrow on the same tick.

When both digits sit at zero in run, counting halts and the alarm output rises. The alarm stays high until start/stop is pressed, and that press returns the timer to idle. Display decoding, debouncing and tick generation are left to the surrounding logic.

Top module: `bcd_countdown_timer`

## Requirements
- R1: While reset is active (rstN low) and on the first cycle after it, both digits read 0 and alarm is low. The controller starts in idle.
- R2: Each digit always reads a value from 0 to 9. An increment from 9 gives 0.
- R3: In idle or stop, a set-tens pulse selects the set-tens phase and a set-ones pulse selects the set-ones phase, without changing any digit. Set-tens wins when both set buttons are pulsed together. Start/stop wins over both.
- R4: In the set-tens phase, a set-tens pulse adds one to the tens digit only, and a set-ones pulse moves to the set-ones phase with no digit change. The set-ones phase mirrors this with the roles swapped.
- R5: Start/stop moves idle, set-tens, set-ones or stop to run. In run without alarm, start/stop moves to stop, and the digits keep their values.
- R6: In run without alarm and not at 00, each tick takes one from the ones digit one clock later. If the ones digit was 0, it becomes 9 and the tens digit drops by one on the same edge.
- R7: Ticks outside run have no effect on the digits, and neither do set pulses in run.
- R8: When run sees both digits at 0, counting halts and alarm rises on the next clock edge. Alarm is only ever high while both digits are 0.
- R9: Once high, alarm stays high and the digits stay frozen until a start/stop pulse. That pulse drops alarm on the next edge and returns the timer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStopBtn | input | 1 | Start/stop pulse, one cycle wide |
| setTensBtn | input | 1 | Tens-digit set pulse, one cycle wide |
| setOnesBtn | input | 1 | Ones-digit set pulse, one cycle wide |
| tick | input | 1 | Countdown enable, one cycle wide |
| tensDigit | output | DIGIT_W | BCD tens digit |
| onesDigit | output | DIGIT_W | BCD ones digit |
| alarm | output | 1 | High once the countdown has reached 00 |

## Verification
The bench builds the timer with its default widths: a 4-bit digit with a top value of 9, which is plain decimal. This setting brings the decimal wraps within reach: 9 to 0 while setting, and 0 to 9 with a borrow while counting. It also reaches the 00 stop point, where the alarm logic works. Random button and tick traffic reaches every phase change. Directed runs cover the borrow from 10 to 09, the countdown to 00, and a full ten-press wrap of a set digit.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SET_HI,
    PH_SET_LO,
    PH_RUN,
    PH_STOP
  } phase_t;

  // Strobes from the controller to the two digit cells.
  typedef struct packed {
    logic hiUp;
    logic hiDn;
    logic loUp;
    logic loDn;
  } digit_strobe_t;

endpackage

// File: rtl/timer_digit.sv
module timer_digit #(
  parameter int W    = 4,
  parameter int MAXV = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         countUp,
  input  logic         countDn,
  output logic [W-1:0] value,
  output logic         atZero
);

  localparam logic [W-1:0] TopVal = W'(MAXV);

  logic         atMax;
  logic [W-1:0] nextVal;

  assign atZero = (value == '0);
  assign atMax  = (value == TopVal);

  // Both strobes or neither: hold.
  always_comb begin
    nextVal = value;
    if (countUp && !countDn) begin
      nextVal = atMax ? '0 : value + W'(1);
    end else if (countDn && !countUp) begin
      nextVal = atZero ? TopVal : value - W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) value <= '0;
    else       value <= nextVal;
  end

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int W    = 4,
  parameter int MAXV = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  digit_strobe_t strobe,
  output logic [W-1:0]  tensVal,
  output logic [W-1:0]  onesVal,
  output logic          tensZero,
  output logic          onesZero
);

  localparam int NumDigits = 2;

  logic [NumDigits-1:0] upVec;
  logic [NumDigits-1:0] dnVec;
  logic [NumDigits-1:0] zeroVec;
  logic [W-1:0]         valVec [NumDigits];

  // Index 0 is the ones digit, index 1 the tens digit.
  assign upVec = {strobe.hiUp, strobe.loUp};
  assign dnVec = {strobe.hiDn, strobe.loDn};

  for (genvar d = 0; d < NumDigits; d++) begin : gDigit
    timer_digit #(.W(W), .MAXV(MAXV)) uCell (
      .clk     (clk),
      .rstN    (rstN),
      .countUp (upVec[d]),
      .countDn (dnVec[d]),
      .value   (valVec[d]),
      .atZero  (zeroVec[d])
    );
  end

  assign onesVal  = valVec[0];
  assign tensVal  = valVec[1];
  assign onesZero = zeroVec[0];
  assign tensZero = zeroVec[1];

endmodule

// File: rtl/timer_control.sv
module timer_control
  import timer_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startStop,
  input  logic          setTens,
  input  logic          setOnes,
  input  logic          tick,
  input  logic          tensZero,
  input  logic          onesZero,
  output digit_strobe_t strobe,
  output logic          alarm
);

  phase_t phase, nextPhase;
  logic   nextAlarm;
  logic   bothZero;

  assign bothZero = tensZero & onesZero;

  always_comb begin
    nextPhase = phase;
    nextAlarm = alarm;
    strobe    = '0;
    unique case (phase)
      PH_IDLE, PH_STOP: begin
        if (startStop)    nextPhase = PH_RUN;
        else if (setTens) nextPhase = PH_SET_HI;
        else if (setOnes) nextPhase = PH_SET_LO;
      end
      PH_SET_HI: begin
        if (startStop)    nextPhase = PH_RUN;
        else if (setTens) strobe.hiUp = 1'b1;
        else if (setOnes) nextPhase = PH_SET_LO;
      end
      PH_SET_LO: begin
        if (startStop)    nextPhase = PH_RUN;
        else if (setOnes) strobe.loUp = 1'b1;
        else if (setTens) nextPhase = PH_SET_HI;
      end
      PH_RUN: begin
        if (startStop) begin
          if (alarm) begin
            nextPhase = PH_IDLE;
            nextAlarm = 1'b0;
          end else begin
            nextPhase = PH_STOP;
          end
        end else if (!alarm) begin
          if (bothZero) begin
            nextAlarm = 1'b1;
          end else if (tick) begin
            strobe.loDn = 1'b1;
            strobe.hiDn = onesZero;  // borrow from tens
          end
        end
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      alarm <= 1'b0;
    end else begin
      phase <= nextPhase;
      alarm <= nextAlarm;
    end
  end

endmodule

// File: rtl/bcd_countdown_timer.sv
module bcd_countdown_timer
  import timer_pkg::*;
#(
  parameter int DIGIT_W   = 4,
  parameter int DIGIT_MAX = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStopBtn,
  input  logic               setTensBtn,
  input  logic               setOnesBtn,
  input  logic               tick,
  output logic [DIGIT_W-1:0] tensDigit,
  output logic [DIGIT_W-1:0] onesDigit,
  output logic               alarm
);

  digit_strobe_t strobe;
  logic          tensZero;
  logic          onesZero;

  timer_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startStop (startStopBtn),
    .setTens   (setTensBtn),
    .setOnes   (setOnesBtn),
    .tick      (tick),
    .tensZero  (tensZero),
    .onesZero  (onesZero),
    .strobe    (strobe),
    .alarm     (alarm)
  );

  timer_datapath #(.W(DIGIT_W), .MAXV(DIGIT_MAX)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tensVal  (tensDigit),
    .onesVal  (onesDigit),
    .tensZero (tensZero),
    .onesZero (onesZero)
  );

endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int W    = 4,
  parameter int MAXV = 9
) (
  input logic         clk,
  input logic         rstN,
  input logic         startStop,
  input logic         setTens,
  input logic         setOnes,
  input logic         tick,
  input logic [W-1:0] tens,
  input logic [W-1:0] ones,
  input logic         alarm
);

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (tens <= W'(MAXV)) && (ones <= W'(MAXV))); // R2

  AST_ALARM_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    alarm |-> (tens == '0) && (ones == '0)); // R8

  AST_ALARM_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    alarm && !startStop |=> alarm); // R9

  AST_ALARM_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    alarm && startStop |=> !alarm); // R9

  AST_ALARM_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    alarm |=> $stable(tens) && $stable(ones)); // R9

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tick && !setTens && !setOnes |=> $stable(tens) && $stable(ones)); // R7

  AST_ONES_STEP: assert property (@(posedge clk) disable iff (!rstN)
    tick && !setTens && !setOnes && (ones != '0)
      |=> (ones == $past(ones)) || (ones == $past(ones) - W'(1))); // R6

endmodule

bind bcd_countdown_timer timer_checker #(.W(DIGIT_W), .MAXV(DIGIT_MAX)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .startStop (startStopBtn),
  .setTens   (setTensBtn),
  .setOnes   (setOnesBtn),
  .tick      (tick),
  .tens      (tensDigit),
  .ones      (onesDigit),
  .alarm     (alarm)
);

// File: tb/tb_bcd_countdown_timer.sv
module tb_bcd_countdown_timer;

  logic       clk = 1'b0;
  logic       rstN;
  logic       startStopBtn, setTensBtn, setOnesBtn, tick;
  logic [3:0] tensDigit, onesDigit;
  logic       alarm;

  always #4 clk = ~clk;  // 125 MHz

  bcd_countdown_timer dut (
    .clk          (clk),
    .rstN         (rstN),
    .startStopBtn (startStopBtn),
    .setTensBtn   (setTensBtn),
    .setOnesBtn   (setOnesBtn),
    .tick         (tick),
    .tensDigit    (tensDigit),
    .onesDigit    (onesDigit),
    .alarm        (alarm)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Reference model: 0 idle, 1 set tens, 2 set ones, 3 run, 4 stop
  int    mPhase = 0;
  int    mTens = 0;
  int    mOnes = 0;
  int    mAlarm = 0;
  string mTag = "R1";

  function automatic int incDigit(int v);
    return (v == 9) ? 0 : v + 1;
  endfunction

  function automatic int decDigit(int v);
    return (v == 0) ? 9 : v - 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check({mTag, " tens"}, int'(tensDigit), mTens);
    check({mTag, " ones"}, int'(onesDigit), mOnes);
    check({mTag, " alarm"}, int'(alarm), mAlarm);
  endtask

  task automatic modelStep(bit ss, bit st, bit so, bit tk);
    mTag = "R7";
    case (mPhase)
      0, 4: begin
        if (ss)      begin mPhase = 3; mTag = "R5"; end
        else if (st) begin mPhase = 1; mTag = "R3"; end
        else if (so) begin mPhase = 2; mTag = "R3"; end
      end
      1: begin
        if (ss)      begin mPhase = 3; mTag = "R5"; end
        else if (st) begin mTag = (mTens == 9) ? "R2" : "R4"; mTens = incDigit(mTens); end
        else if (so) begin mPhase = 2; mTag = "R4"; end
      end
      2: begin
        if (ss)      begin mPhase = 2 + 1; mTag = "R5"; end
        else if (so) begin mTag = (mOnes == 9) ? "R2" : "R4"; mOnes = incDigit(mOnes); end
        else if (st) begin mPhase = 1; mTag = "R4"; end
      end
      default: begin
        if (ss) begin
          if (mAlarm != 0) begin mPhase = 0; mAlarm = 0; mTag = "R9"; end
          else begin mPhase = 4; mTag = "R5"; end
        end else if (mAlarm != 0) begin
          mTag = "R9";
        end else if (mTens == 0 && mOnes == 0) begin
          mAlarm = 1; mTag = "R8";
        end else if (tk) begin
          mTag = "R6";
          if (mOnes == 0) mTens = decDigit(mTens);
          mOnes = decDigit(mOnes);
        end
      end
    endcase
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cycle(bit ss, bit st, bit so, bit tk);
    startStopBtn = ss;
    setTensBtn   = st;
    setOnesBtn   = so;
    tick         = tk;
    modelStep(ss, st, so, tk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic printSummary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog (R1..R9 run): actual timeout expected completion");
      printSummary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    startStopBtn = 0; setTensBtn = 0; setOnesBtn = 0; tick = 0;
    repeat (3) @(negedge clk);
    mTag = "R1";
    compareAll();  // R1 during reset
    rstN = 1'b1;
    cycle(0, 0, 0, 0);  // R1 after release

    // Directed: set 10, count to 00, alarm, release
    cycle(0, 1, 0, 0);          // R3 enter set tens
    cycle(0, 1, 0, 0);          // R4 tens = 1
    cycle(0, 0, 1, 0);          // R4 move to set ones
    cycle(0, 0, 0, 1);          // R7 tick ignored
    cycle(1, 0, 0, 0);          // R5 run
    cycle(0, 0, 0, 1);          // R6 borrow 10 -> 09
    for (int k = 0; k < 9; k++) cycle(0, 0, 0, 1);
    cycle(0, 0, 0, 0);          // R8 alarm rises
    cycle(0, 0, 0, 1);          // R9 frozen
    cycle(0, 1, 1, 1);          // R7/R9 set ignored in run
    cycle(1, 0, 0, 0);          // R9 release to idle

    // Directed: ten presses of set ones wrap back to the start value (R2)
    cycle(0, 0, 1, 0);
    for (int k = 0; k < 10; k++) cycle(0, 0, 1, 0);
    cycle(1, 0, 0, 0);          // R5 run
    cycle(1, 0, 0, 0);          // R5 stop, digits held

    // Constrained random traffic
    void'($urandom(32'd20240611));
    for (int n = 0; n < 6000; n++) begin
      bit ss, st, so, tk;
      ss = ($urandom_range(0, 99) < 6);
      st = ($urandom_range(0, 99) < 12);
      so = ($urandom_range(0, 99) < 12);
      tk = ($urandom_range(0, 99) < 40);
      cycle(ss, st, so, tk);
    end

    finished = 1;
    printSummary();
    $finish;
  end

endmodule